// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the serial test port of a memory device. A tester drives a test clock, a mode-select line and a serial data input. A 16-state controller steers those bits into either a 3-bit instruction register or one data register. The data register can be a 1-bit bypass stage, a 32-bit identification word or a boundary register of parameter length. Serial results leave on `tdo`, which changes on the falling test-clock edge and is enabled only while shifting.

The boundary register takes a parallel snapshot from the device pins during capture. It presents a parallel update image toward the pins. One cell of that image is reserved as the output-bus enable. While the external-test instruction is current, that cell alone decides whether the memory's data outputs are driven. Under every other instruction, the device's own output enable passes through unchanged.

Top module: `memtap_top`

## Requirements
- R1: Five consecutive rising edges with `tms` high bring the controller to its reset state from any state. The reset state, or `trst_n` low, makes the identification instruction current.
- R2: In the instruction-capture state the instruction shifter loads 3'b001 (bits [1:0] = 01, bit 2 = 0), shifted out least significant bit first.
- R3: Instruction codes: 3'b000 external test, 3'b001 identification, 3'b100 sample/preload, 3'b111 bypass. Codes 010, 011, 101 and 110 select the bypass register.
- R4: The bypass register captures 0 and gives a one-stage delay from `tdi` to `tdo` while shifting.
- R5: The identification register holds the 32-bit parameter `ID_VALUE`, shifted out least significant bit first, and its bit 0 is 1.
- R6: `BSR_LEN` may only be 89 or 138. Under external test or sample/preload, data capture loads `pin_capture`; bit 0 leaves first. A bit entered on `tdi` reappears on `tdo` after `BSR_LEN` shifts.
- R7: Data update under external test or sample/preload copies the boundary shifter to `pin_update`. Data scans under other instructions leave `pin_update` unchanged.
- R8: Bit `TRI_POS` (default 0) of `pin_update` is the output-bus cell. While external test is current, `dq_oe` equals that bit (1 = drive) and `extest_mode` is 1. Otherwise `dq_oe` follows `core_oe`.
- R9: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` update on the falling edge. `tdo_oe` is 1 only in the instruction-shift and data-shift states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_capture | input | BSR_LEN | Parallel pin snapshot for boundary capture |
| pin_update | output | BSR_LEN | Boundary update image toward the pins |
| extest_mode | output | 1 | External-test instruction is current |
| core_oe | input | 1 | Device's functional data-output enable |
| dq_oe | output | 1 | Final data-output driver enable |

## Verification
Every 3-bit instruction code is walked, so a decoder that sends a reserved code anywhere but bypass shows up as a wrong serial stream. The instruction capture pattern is checked, so a design loading the old instruction instead of 01 is caught. The boundary register is shifted past its full length, so an off-by-one chain returns the wrong bits or skews the `tdi` echo. The output-bus cell is preloaded both ways and swapped in and out of external test against an opposite `core_oe`, so a mux gated on the wrong instruction drives or floats the bus when it should not. A five-edge `tms` escape from the middle of a data shift must restore the identification instruction.

// File: rtl/memtap_pkg.sv
package memtap_pkg;
   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
   localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
   import memtap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);
   tap_state_e nxt;

   always_comb begin
      unique case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

   // run of consecutive high tms samples, saturating at five
   logic [2:0] tms_run;
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)            tms_run <= 3'd0;
      else if (!tms)         tms_run <= 3'd0;
      else if (tms_run != 5) tms_run <= tms_run + 3'd1;
   end

   assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
      (tms_run == 3'd5) |-> (state == ST_RESET));
endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
   import memtap_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir,
   output logic            ir_lsb
);
   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
         ir <= OP_IDENT;
      end else begin
         case (state)
            ST_RESET:  ir <= OP_IDENT;
            ST_CAP_IR: sr <= {{(IR_W-2){1'b0}}, 2'b01};
            ST_SH_IR:  sr <= {tdi, sr[IR_W-1:1]};
            ST_UPD_IR: ir <= sr;
            default:   ;
         endcase
      end
   end

   assign ir_lsb = sr[0];

   assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_CAP_IR) |=> (sr[1:0] == 2'b01));
   assert_reset_ident_R1: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_RESET) |=> (ir == OP_IDENT));
endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
   import memtap_pkg::*;
#(
   parameter int          BSR_LEN  = 89,
   parameter logic [31:0] ID_VALUE = 32'h2B61_4069
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic               tdi,
   input  tap_state_e         state,
   input  logic [IR_W-1:0]    ir,
   input  logic [BSR_LEN-1:0] pins_in,
   output logic               dr_lsb,
   output logic [BSR_LEN-1:0] bsr_upd
);
   localparam int ID_W = 32;

   logic               sel_bsr, sel_id, sel_byp;
   logic               byp;
   logic [ID_W-1:0]    id_sr;
   logic [BSR_LEN-1:0] bsr_sr;

   assign sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
   assign sel_id  = (ir == OP_IDENT);
   assign sel_byp = !sel_bsr && !sel_id;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp     <= 1'b0;
         id_sr   <= ID_VALUE;
         bsr_sr  <= '0;
         bsr_upd <= '0;
      end else begin
         case (state)
            ST_CAP_DR: begin
               if (sel_bsr)     bsr_sr <= pins_in;
               else if (sel_id) id_sr  <= ID_VALUE;
               else             byp    <= 1'b0;
            end
            ST_SH_DR: begin
               if (sel_bsr)     bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
               else if (sel_id) id_sr  <= {tdi, id_sr[ID_W-1:1]};
               else             byp    <= tdi;
            end
            ST_UPD_DR: if (sel_bsr) bsr_upd <= bsr_sr;
            default: ;
         endcase
      end
   end

   assign dr_lsb = sel_bsr ? bsr_sr[0] : (sel_id ? id_sr[0] : byp);

   assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_CAP_DR && sel_byp) |=> (byp == 1'b0));
   assert_update_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
      (state != ST_UPD_DR) |=> $stable(bsr_upd));
endmodule

// File: rtl/memtap_top.sv
module memtap_top
   import memtap_pkg::*;
#(
   parameter int          BSR_LEN  = 89,
   parameter logic [31:0] ID_VALUE = 32'h2B61_4069,
   parameter int          TRI_POS  = 0,
   parameter bit          USE_TRST = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [BSR_LEN-1:0] pin_capture,
   output logic [BSR_LEN-1:0] pin_update,
   output logic               extest_mode,
   input  logic               core_oe,
   output logic               dq_oe
);
   // elaboration-time parameter checks
   if (BSR_LEN != 89 && BSR_LEN != 138) begin : g_bad_len
      $error("memtap_top: BSR_LEN must be 89 or 138");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("memtap_top: ID_VALUE bit 0 must be 1");
   end
   if (TRI_POS < 0 || TRI_POS >= BSR_LEN) begin : g_bad_tri
      $error("memtap_top: TRI_POS outside boundary register");
   end

   logic rst_n;
   if (USE_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_e      state;
   logic [IR_W-1:0] ir;
   logic            ir_lsb, dr_lsb;

   memtap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

   memtap_ir u_ir (.tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
                   .ir(ir), .ir_lsb(ir_lsb));

   memtap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .ir(ir),
      .pins_in(pin_capture), .dr_lsb(dr_lsb), .bsr_upd(pin_update));

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
         tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
      end
   end

   assign extest_mode = (ir == OP_EXTEST);
   assign dq_oe       = extest_mode ? pin_update[TRI_POS] : core_oe;

   assert_oe_only_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

// File: tb/tb_memtap_top.sv
`timescale 1ns/1ps
module tb_memtap_top;
   localparam int          L    = 89;
   localparam logic [31:0] IDV  = 32'h2B61_4069;

   logic         tck = 1'b0;
   logic         trst_n = 1'b0;
   logic         tms = 1'b1;
   logic         tdi = 1'b0;
   logic         core_oe = 1'b0;
   logic [L-1:0] pin_capture;
   logic         tdo, tdo_oe, extest_mode, dq_oe;
   logic [L-1:0] pin_update;

   always #2.5 tck = ~tck;

   memtap_top #(.BSR_LEN(L), .ID_VALUE(IDV), .TRI_POS(0)) dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .tdo_oe(tdo_oe), .pin_capture(pin_capture), .pin_update(pin_update),
      .extest_mode(extest_mode), .core_oe(core_oe), .dq_oe(dq_oe));

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // {code, kind}: kind 0 = bypass, 1 = identification, 2 = boundary
   localparam logic [4:0] VEC [8] = '{
      {3'b000, 2'd2}, {3'b001, 2'd1}, {3'b010, 2'd0}, {3'b011, 2'd0},
      {3'b100, 2'd2}, {3'b101, 2'd0}, {3'b110, 2'd0}, {3'b111, 2'd0}};

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic go_shift_dr();
      tick(1, 0); tick(0, 0); tick(0, 0);
   endtask

   task automatic go_shift_ir();
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
   endtask

   // shift n bits, leave through update to idle
   task automatic shift(input int n, input logic [255:0] din, output logic [255:0] dout,
                        output logic oe_seen);
      dout = '0;
      oe_seen = tdo_oe;
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tick(i == n - 1, din[i]);
      end
      tick(1, 0);
      tick(0, 0);
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
      logic [255:0] o;
      logic oe;
      go_shift_ir();
      shift(3, {253'd0, code}, o, oe);
      cap = o[2:0];
   endtask

   initial begin
      logic [255:0] o, din, exp;
      logic oe;
      logic [2:0] cap;
      logic [L-1:0] saved;

      pin_capture = {3{32'hC3A5_0F96}} >> (96 - L);
      repeat (3) @(posedge tck);
      @(negedge tck); #1;
      trst_n = 1'b1;

      // reset state
      check("R9 tdo_oe low after reset", {255'd0, tdo_oe}, 256'd0);
      check("R8 dq_oe follows core_oe after reset", {255'd0, dq_oe}, 256'd0);
      tick(0, 0);
      go_shift_dr();
      check("R9 tdo_oe high in data shift", {255'd0, tdo_oe}, 256'd1);
      shift(32, 256'd0, o, oe);
      check("R1 R5 identification selected after trst", o[31:0], IDV);
      check("R5 id bit0 is one", {255'd0, o[0]}, 256'd1);
      check("R9 tdo_oe low in idle", {255'd0, tdo_oe}, 256'd0);

      // instruction table walk (R3)
      for (int v = 0; v < 8; v++) begin
         load_ir(VEC[v][4:2], cap);
         if (v == 0) check("R2 capture-IR pattern 001", {253'd0, cap}, 256'd1);
         din = {224'd0, 32'h9E37_79B1} ^ (v * 32'h0101_0101);
         go_shift_dr();
         shift(32, din, o, oe);
         case (VEC[v][1:0])
            2'd0: exp = {224'd0, din[30:0], 1'b0};
            2'd1: exp = {224'd0, IDV};
            default: exp = {224'd0, pin_capture[31:0]};
         endcase
         check($sformatf("R3 R4 R5 R6 code %0d data path", VEC[v][4:2]), o, exp);
      end

      // full-length boundary shift under sample/preload, output cell = 1
      load_ir(3'b100, cap);
      check("R2 capture-IR holds 01 after non-reset instr", {253'd0, cap}, 256'd1);
      din = '0;
      for (int i = 0; i < L + 8; i++) din[i] = ((i * 7 + 3) % 5) < 2;
      din[8] = 1'b1;                   // lands in cell 0 after L+8 shifts
      go_shift_dr();
      shift(L + 8, din, o, oe);
      exp = '0;
      for (int i = 0; i < L; i++) exp[i] = pin_capture[i];
      for (int i = 0; i < 8; i++) exp[L + i] = din[i];
      check("R6 boundary capture and length", o, exp);
      exp = '0;
      for (int i = 0; i < L; i++) exp[i] = din[i + 8];
      check("R7 update copies boundary image", {{(256-L){1'b0}}, pin_update}, exp);
      core_oe = 1'b0;
      #1;
      check("R8 sample mode leaves dq_oe to core", {255'd0, dq_oe}, 256'd0);
      check("R8 extest_mode low under sample", {255'd0, extest_mode}, 256'd0);

      // external test: preloaded cell drives bus despite core_oe = 0
      load_ir(3'b000, cap);
      check("R8 extest_mode high", {255'd0, extest_mode}, 256'd1);
      check("R8 cell=1 drives under extest", {255'd0, dq_oe}, 256'd1);

      // clear the cell under extest with core_oe = 1
      core_oe = 1'b1;
      din = '0;
      for (int i = 1; i < L; i++) din[i] = 1'b1;
      go_shift_dr();
      shift(L, din, o, oe);
      check("R8 cell=0 floats bus under extest", {255'd0, dq_oe}, 256'd0);
      saved = pin_update;

      // bypass scans leave the update image alone
      load_ir(3'b111, cap);
      check("R8 bypass returns dq_oe to core", {255'd0, dq_oe}, 256'd1);
      go_shift_dr();
      shift(40, {216'd0, 40'hFF_FFFF_FFFF}, o, oe);
      check("R7 bypass scan keeps pin_update", {{(256-L){1'b0}}, pin_update},
            {{(256-L){1'b0}}, saved});
      check("R4 bypass one-stage delay", o[39:0], {40'hFF_FFFF_FFFE});

      // five tms-high edges from mid data shift
      go_shift_dr();
      tick(0, 1); tick(0, 0);
      for (int i = 0; i < 5; i++) tick(1, 0);
      check("R9 tdo_oe low after escape", {255'd0, tdo_oe}, 256'd0);
      tick(0, 0);
      go_shift_dr();
      shift(32, 256'd0, o, oe);
      check("R1 five tms reset selects identification", o[31:0], IDV);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule